// File: doc/BRIEF.md
# Sixteen-Bit Eight-Function ALU

This block is the arithmetic and logic unit of a small 16-bit processor datapath. It takes two operands and a 3-bit function code, and it returns a 16-bit result in the same cycle, with no clock and no stored state. The eight functions are: bitwise OR, AND and XOR; add and subtract, both wrapping; a variable left shift; a variable logical right shift; and a signed set-less-than.

Branch logic uses a separate equality flag, which the block drives whatever the function code is. The block does not detect or report overflow or carry.

The function code is decoded into a named set of operations (fn_or, fn_and, fn_add, fn_sub, fn_shl, fn_shr, fn_xor, fn_slt). A single selection step routes the output of the matching sub-unit to the result. There is one sub-unit for bitwise logic, one for add and subtract, and one barrel shifter for each shift direction.

Top module: `alu16_core`

## Requirements
- R1: With func = 0 the result is op_a | op_b. With func = 1 the result is op_a & op_b.
- R2: With func = 2 the result is (op_a + op_b) mod 2^16. The carry out is discarded.
- R3: With func = 3 the result is (op_a - op_b) mod 2^16. The borrow is discarded.
- R4: With func = 4 the result is op_a shifted left by op_b[3:0] places, with zeros filling the low end. op_b[15:4] has no effect.
- R5: With func = 5 the result is op_a shifted right by op_b[3:0] places, with zeros filling the high end. op_b[15:4] has no effect.
- R6: With func = 6 the result is op_a ^ op_b.
- R7: With func = 7 the result is 16'h0001 when op_a is less than op_b, comparing both as signed two's-complement values. Otherwise the result is 16'h0000.
- R8: equal is 1 exactly when op_a equals op_b, for every value of func.
- R9: The outputs depend only on the present inputs. A new input pattern is reflected in the outputs without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 16 | First operand |
| op_b | input | 16 | Second operand; its low 4 bits are the shift amount |
| func | input | 3 | Function code selecting the operation |
| result | output | 16 | Result of the selected operation |
| equal | output | 1 | High when the operands are equal |

## Verification
The block holds no state, so an internal fault cannot stay hidden. A wrong sub-unit output or a wrong selection arm appears on result as soon as the input pattern that reaches it is applied. If the equality logic is faulty, equal disagrees with the operands on the first pattern where the faulty logic matters.

The stimulus covers operands that reveal sign handling, carry wrap, the full shift range and the effect of the ignored upper shift bits. A wrong decode of a function code is therefore seen within one sampled pattern for that code.

// File: rtl/alu16_pkg.sv
package alu16_pkg;

    typedef enum logic [2:0] {
        FN_OR  = 3'd0,
        FN_AND = 3'd1,
        FN_ADD = 3'd2,
        FN_SUB = 3'd3,
        FN_SHL = 3'd4,
        FN_SHR = 3'd5,
        FN_XOR = 3'd6,
        FN_SLT = 3'd7
    } alu_fn_e;

endpackage

// File: rtl/alu16_logic.sv
module alu16_logic #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic [WIDTH-1:0] or_r,
    output logic [WIDTH-1:0] and_r,
    output logic [WIDTH-1:0] xor_r,
    output logic             same
);
    always_comb begin
        or_r  = a | b;
        and_r = a & b;
        xor_r = a ^ b;
        same  = ~|(a ^ b);
    end
endmodule

// File: rtl/alu16_addsub.sv
module alu16_addsub #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic [WIDTH-1:0] sum,
    output logic [WIDTH-1:0] diff,
    output logic             less
);
    logic [WIDTH:0] diff_ext;

    always_comb begin
        sum      = a + b;
        diff_ext = {a[WIDTH-1], a} - {b[WIDTH-1], b};
        diff     = diff_ext[WIDTH-1:0];
        less     = diff_ext[WIDTH];
    end
endmodule

// File: rtl/alu16_shift.sv
module alu16_shift #(
    parameter int WIDTH = 16,
    parameter int SHW   = 4,
    parameter bit RIGHT = 1'b0
) (
    input  logic [WIDTH-1:0] din,
    input  logic [SHW-1:0]   amt,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] stage [0:SHW];

    assign stage[0] = din;

    for (genvar i = 0; i < SHW; i++) begin : g_stage
        localparam int STEP = 1 << i;
        if (RIGHT) begin : g_right
            assign stage[i+1] = amt[i] ? (stage[i] >> STEP) : stage[i];
        end else begin : g_left
            assign stage[i+1] = amt[i] ? (stage[i] << STEP) : stage[i];
        end
    end

    assign dout = stage[SHW];
endmodule

// File: rtl/alu16_core.sv
module alu16_core
    import alu16_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic [2:0]       func,
    output logic [WIDTH-1:0] result,
    output logic             equal
);
    localparam int SHW = $clog2(WIDTH);

    alu_fn_e          fn;
    logic [WIDTH-1:0] or_r, and_r, xor_r, sum_r, diff_r, shl_r, shr_r;
    logic             same, less;

    assign fn = alu_fn_e'(func);

    alu16_logic #(.WIDTH(WIDTH)) u_logic (
        .a(op_a), .b(op_b), .or_r(or_r), .and_r(and_r), .xor_r(xor_r), .same(same)
    );

    alu16_addsub #(.WIDTH(WIDTH)) u_addsub (
        .a(op_a), .b(op_b), .sum(sum_r), .diff(diff_r), .less(less)
    );

    alu16_shift #(.WIDTH(WIDTH), .SHW(SHW), .RIGHT(1'b0)) u_shl (
        .din(op_a), .amt(op_b[SHW-1:0]), .dout(shl_r)
    );

    alu16_shift #(.WIDTH(WIDTH), .SHW(SHW), .RIGHT(1'b1)) u_shr (
        .din(op_a), .amt(op_b[SHW-1:0]), .dout(shr_r)
    );

    always_comb begin
        unique case (fn)
            FN_OR:   result = or_r;
            FN_AND:  result = and_r;
            FN_ADD:  result = sum_r;
            FN_SUB:  result = diff_r;
            FN_SHL:  result = shl_r;
            FN_SHR:  result = shr_r;
            FN_XOR:  result = xor_r;
            FN_SLT:  result = {{(WIDTH-1){1'b0}}, less};
            default: result = '0;
        endcase
        equal = same;
    end

    always_comb begin
        assert_equal_flag_R8: assert (equal == (op_a == op_b))
            else $error("equal flag disagrees with operands");
        if (fn == FN_ADD) begin
            assert_add_wrap_R2: assert (WIDTH'(result - op_b) == op_a)
                else $error("add result inconsistent");
        end
        if (fn == FN_SUB) begin
            assert_sub_wrap_R3: assert (WIDTH'(result + op_b) == op_a)
                else $error("sub result inconsistent");
        end
        if (fn == FN_XOR) begin
            assert_xor_undo_R6: assert ((result ^ op_b) == op_a)
                else $error("xor result inconsistent");
        end
        if (fn == FN_SLT) begin
            assert_slt_bool_R7: assert (result[WIDTH-1:1] == '0)
                else $error("slt result not boolean");
        end
        if (fn == FN_SHL && op_b[SHW-1:0] == '0) begin
            assert_shl_zero_R4: assert (result == op_a)
                else $error("zero left shift altered operand");
        end
        if (fn == FN_SHR) begin
            assert_shr_fill_R5: assert ((result & ~(op_a >> op_b[SHW-1:0])) == '0)
                else $error("right shift set a bit outside the source");
        end
    end
endmodule

// File: tb/alu16_core_test.sv
module alu16_core_test;
    logic        clk = 1'b0;
    logic [15:0] op_a, op_b, result;
    logic [2:0]  func;
    logic        equal;
    int          checks = 0;
    int          errors = 0;
    bit          done   = 1'b0;

    always #10 clk = ~clk;

    alu16_core uut (.op_a(op_a), .op_b(op_b), .func(func), .result(result), .equal(equal));

    function automatic logic [15:0] ref_result(input logic [15:0] a, input logic [15:0] b, input int f);
        case (f)
            0: return a | b;
            1: return a & b;
            2: return 16'((32'(a) + 32'(b)) % 65536);
            3: return 16'((32'(a) + 65536 - 32'(b)) % 65536);
            4: return a << b[3:0];
            5: return a >> b[3:0];
            6: return a ^ b;
            default: return ($signed(a) < $signed(b)) ? 16'd1 : 16'd0;
        endcase
    endfunction

    function automatic string req_of(input int f);
        case (f)
            0, 1: return "R1";
            2: return "R2";
            3: return "R3";
            4: return "R4";
            5: return "R5";
            6: return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic apply_check(input logic [15:0] a, input logic [15:0] b, input int f);
        logic [15:0] exp;
        @(posedge clk);
        op_a = a; op_b = b; func = 3'(f);
        @(negedge clk);
        exp = ref_result(a, b, f);
        checks++;
        if (result !== exp) begin
            errors++;
            $display("FAIL %s: func=%0d a=%h b=%h result=%h expected=%h", req_of(f), f, a, b, result, exp);
        end
        checks++;
        if (equal !== (a == b)) begin
            errors++;
            $display("FAIL R8: func=%0d a=%h b=%h equal=%b expected=%b", f, a, b, equal, a == b);
        end
    endtask

    initial begin
        logic [15:0] corners [12];
        logic [15:0] r;
        void'($urandom(32'd2024));
        corners = '{16'h0000, 16'h0001, 16'hFFFF, 16'h7FFF, 16'h8000, 16'h8001,
                    16'h00F0, 16'h1234, 16'hA5A5, 16'h0010, 16'hFFF3, 16'h000F};
        op_a = '0; op_b = '0; func = '0;
        // R9: combinational response to the first pattern, no clock edge needed
        #1;
        checks++;
        if (result !== 16'h0000 || equal !== 1'b1) begin
            errors++;
            $display("FAIL R9: result=%h equal=%b expected=0000/1", result, equal);
        end
        op_a = 16'h00F0; op_b = 16'h0F00; func = 3'd0;
        #1;
        checks++;
        if (result !== 16'h0FF0 || equal !== 1'b0) begin
            errors++;
            $display("FAIL R9: result=%h equal=%b expected=0ff0/0", result, equal);
        end
        // directed corners: every function over every operand pair
        for (int f = 0; f < 8; f++)
            for (int i = 0; i < 12; i++)
                for (int j = 0; j < 12; j++)
                    apply_check(corners[i], corners[j], f);
        // R4 R5: upper shift bits of op_b ignored
        apply_check(16'h8421, 16'hFFF1, 4);
        apply_check(16'h8421, 16'h0010, 5);
        apply_check(16'h8421, 16'h123F, 5);
        // R7: signed vs unsigned ordering
        apply_check(16'h8000, 16'h0001, 7);
        apply_check(16'h0001, 16'h8000, 7);
        // random patterns
        for (int k = 0; k < 3000; k++) begin
            r = 16'($urandom);
            if (k % 5 == 0) apply_check(r, r, k % 8);
            else apply_check(16'($urandom), 16'($urandom), k % 8);
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule